// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter and Line-Driver Direction Control

This block gives a UART the two functions needed on a shared RS-485 bus. On the receive side it looks at each 9-bit received word. The ninth bit separates node-address words from data words. While filtering is on, the block passes data to the receive path only after an address word equal to this node's programmed address. Everything else is dropped: data that arrives while the node is not selected, and address words for other nodes.

On the transmit side it produces the direction signal for the external line transceiver. The signal turns on as soon as the transmit FIFO holds a character, before the start bit goes out. It stays on while the shifter is busy. After the final stop bit has left the shifter and the FIFO is empty, it stays on for a programmable number of bit ticks, then turns off. The direction signal can be routed to either the RTS or the DTR pin. On the selected pin it overrides both the manual modem-control value and the hardware flow-control value.

Top module: `mdrop_ctl`

## Requirements
- R1: While reset is asserted, `rx_accept` is 0 and the direction signal is inactive. With `auto_dir_en`=1 and `dir_sel`=0, this means `rts_out` is 0 even when `man_rts` is 1.
- R2: With `filt_en`=0, every `rx_valid` word is accepted whatever its ninth bit. `rx_accept` is 1 for one cycle in the cycle after the strobe, and `rx_data` equals `rx_word[7:0]`.
- R3: With `filt_en`=1, a data word (`rx_word[8]`=0) received while no matching address has been seen since filtering was enabled is discarded, so `rx_accept` stays 0.
- R4: With `filt_en`=1, an address word (`rx_word[8]`=1) whose low 8 bits differ from `node_addr` is discarded and deselects the node, so the data words that follow it are discarded too.
- R5: After an address word equal to `node_addr`, data words are accepted. The matching address word is itself passed on when `pass_addr`=1 and dropped when `pass_addr`=0.
- R6: With automatic direction enabled, the direction signal turns on in the cycle after `tx_fifo_empty` goes to 0, and it is off before that.
- R7: The direction signal stays on while `tx_shift_empty`=0. Once both empty flags are 1, it turns off in the cycle after the `turn_delay`-th `bit_tick`. Cycles without a tick do not count.
- R8: With `turn_delay`=0, the direction signal turns off in the cycle after both empty flags are 1.
- R9: If a new character reaches the FIFO during the countdown, the countdown is cancelled and the direction signal stays on. The full `turn_delay` countdown starts again after the next transmission ends.
- R10: With `auto_dir_en`=1, the pin chosen by `dir_sel` (0 = RTS, 1 = DTR) carries the direction signal and ignores `man_rts`, `man_dtr`, `hwfc_en` and `hwfc_rts`. The other pin follows its usual source.
- R11: With `auto_dir_en`=0, `rts_out` equals `hwfc_rts` when `hwfc_en`=1 and equals `man_rts` otherwise, and `dtr_out` equals `man_dtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 9 | Received word; bit 8 = 1 marks an address |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_word` |
| node_addr | input | 8 | Address of this node |
| filt_en | input | 1 | Enable address filtering |
| pass_addr | input | 1 | Forward the matching address word |
| rx_accept | output | 1 | One-cycle strobe: `rx_data` is delivered |
| rx_data | output | 8 | Accepted byte |
| auto_dir_en | input | 1 | Enable automatic direction control |
| dir_sel | input | 1 | Direction pin: 0 = RTS, 1 = DTR |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shifter is idle, stop bit done |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| turn_delay | input | 8 | Turn-around delay in bit times |
| man_rts | input | 1 | Manual RTS value |
| man_dtr | input | 1 | Manual DTR value |
| hwfc_en | input | 1 | Hardware flow control drives RTS |
| hwfc_rts | input | 1 | RTS value from flow control |
| rts_out | output | 1 | RTS pin |
| dtr_out | output | 1 | DTR pin |

## Verification
The assertions take for granted a few things about the UART around this block. `rx_valid` is a single-cycle strobe. `tx_shift_empty` drops no later than the cycle in which `tx_fifo_empty` rises, so the block never sees both flags high in the middle of a character. `auto_dir_en` stays constant during a transmission. The stimulus respects all three: it moves the FIFO flag and the shifter flag on the same edge, it gives `rx_valid` one-cycle pulses with idle gaps, and it changes configuration only while the direction signal is off.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;

  typedef enum logic {
    PIN_RTS = 1'b0,
    PIN_DTR = 1'b1
  } dir_pin_e;
endpackage

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W:0]   rx_word,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              filt_en,
  input  logic              pass_addr,
  output logic              acc_q,
  output logic [DATA_W-1:0] acc_data_q,
  output logic              matched
);
  localparam int FLAG_BIT = DATA_W;

  logic              match_q, match_d;
  logic              acc_d;
  logic              hit;
  logic              is_addr;

  assign is_addr = rx_word[FLAG_BIT];
  assign hit     = (rx_word[DATA_W-1:0] == node_addr);

  always_comb begin
    match_d = match_q;
    acc_d   = 1'b0;
    if (!filt_en) begin
      match_d = 1'b0;
      acc_d   = rx_valid;
    end else if (rx_valid) begin
      if (is_addr) begin
        match_d = hit;
        acc_d   = hit && pass_addr;
      end else begin
        acc_d   = match_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q    <= 1'b0;
      acc_q      <= 1'b0;
      acc_data_q <= '0;
    end else begin
      match_q <= match_d;
      acc_q   <= acc_d;
      if (acc_d) begin
        acc_data_q <= rx_word[DATA_W-1:0];
      end
    end
  end

  assign matched = match_q;
endmodule

// File: rtl/mdrop_dir_ctl.sv
module mdrop_dir_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             tx_fifo_empty,
  input  logic             tx_shift_empty,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] turn_delay,
  output logic             dir_on,
  output logic             in_send
);
  import mdrop_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  dir_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy = !tx_fifo_empty || !tx_shift_empty;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!auto_en) begin
      state_d = DIR_IDLE;
    end else begin
      case (state_q)
        DIR_IDLE: begin
          if (!tx_fifo_empty) state_d = DIR_SEND;
        end
        DIR_SEND: begin
          if (!busy) begin
            if (turn_delay == '0) begin
              state_d = DIR_IDLE;
            end else begin
              state_d = DIR_HOLD;
              cnt_d   = turn_delay;
            end
          end
        end
        DIR_HOLD: begin
          if (busy) begin
            state_d = DIR_SEND;
          end else if (bit_tick) begin
            if (cnt_q == CNT_ONE) state_d = DIR_IDLE;
            else                  cnt_d   = cnt_q - CNT_ONE;
          end
        end
        default: state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dir_on  = (state_q != DIR_IDLE);
  assign in_send = (state_q == DIR_SEND);
endmodule

// File: rtl/mdrop_pin_mux.sv
module mdrop_pin_mux (
  input  logic auto_en,
  input  logic dir_sel,
  input  logic dir_on,
  input  logic man_rts,
  input  logic man_dtr,
  input  logic hwfc_en,
  input  logic hwfc_rts,
  output logic rts_out,
  output logic dtr_out
);
  import mdrop_pkg::*;

  logic rts_base;
  logic own_rts, own_dtr;

  always_comb begin
    rts_base = hwfc_en ? hwfc_rts : man_rts;
    own_rts  = auto_en && (dir_pin_e'(dir_sel) == PIN_RTS);
    own_dtr  = auto_en && (dir_pin_e'(dir_sel) == PIN_DTR);
    rts_out  = own_rts ? dir_on : rts_base;
    dtr_out  = own_dtr ? dir_on : man_dtr;
  end
endmodule

// File: rtl/mdrop_ctl.sv
module mdrop_ctl #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W:0]   rx_word,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              filt_en,
  input  logic              pass_addr,
  output logic              rx_accept,
  output logic [DATA_W-1:0] rx_data,
  input  logic              auto_dir_en,
  input  logic              dir_sel,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  input  logic              bit_tick,
  input  logic [CNT_W-1:0]  turn_delay,
  input  logic              man_rts,
  input  logic              man_dtr,
  input  logic              hwfc_en,
  input  logic              hwfc_rts,
  output logic              rts_out,
  output logic              dtr_out
);
  logic rst_meta, rst_sync_n;
  logic dir_on, in_send, matched;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mdrop_addr_filter #(.DATA_W(DATA_W)) u_filt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid),
    .node_addr  (node_addr),
    .filt_en    (filt_en),
    .pass_addr  (pass_addr),
    .acc_q      (rx_accept),
    .acc_data_q (rx_data),
    .matched    (matched)
  );

  mdrop_dir_ctl #(.CNT_W(CNT_W)) u_dir (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .auto_en        (auto_dir_en),
    .tx_fifo_empty  (tx_fifo_empty),
    .tx_shift_empty (tx_shift_empty),
    .bit_tick       (bit_tick),
    .turn_delay     (turn_delay),
    .dir_on         (dir_on),
    .in_send        (in_send)
  );

  mdrop_pin_mux u_pins (
    .auto_en  (auto_dir_en),
    .dir_sel  (dir_sel),
    .dir_on   (dir_on),
    .man_rts  (man_rts),
    .man_dtr  (man_dtr),
    .hwfc_en  (hwfc_en),
    .hwfc_rts (hwfc_rts),
    .rts_out  (rts_out),
    .dtr_out  (dtr_out)
  );
endmodule

// File: rtl/mdrop_ctl_chk.sv
module mdrop_ctl_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W:0]   rx_word,
  input logic              rx_valid,
  input logic [DATA_W-1:0] node_addr,
  input logic              filt_en,
  input logic              rx_accept,
  input logic              auto_dir_en,
  input logic              tx_fifo_empty,
  input logic              tx_shift_empty,
  input logic [CNT_W-1:0]  turn_delay,
  input logic              dir_on,
  input logic              in_send,
  input logic              matched
);
  p_accept_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> $past(rx_valid));

  p_drop_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && rx_valid && !rx_word[DATA_W] && !matched) |=> !rx_accept);

  p_drop_foreign_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && rx_valid && rx_word[DATA_W] && (rx_word[DATA_W-1:0] != node_addr))
      |=> (!rx_accept && !matched));

  p_dir_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_on) |-> $past(!tx_fifo_empty && auto_dir_en));

  p_dir_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_on && auto_dir_en && !tx_shift_empty) |=> (dir_on || !$past(auto_dir_en)));

  p_dir_fall_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_on) |-> ($past(tx_fifo_empty && tx_shift_empty) || !$past(auto_dir_en)));

  p_zero_delay_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && tx_fifo_empty && tx_shift_empty && turn_delay == '0) |=> !dir_on);
endmodule

bind mdrop_ctl mdrop_ctl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .rx_word        (rx_word),
  .rx_valid       (rx_valid),
  .node_addr      (node_addr),
  .filt_en        (filt_en),
  .rx_accept      (rx_accept),
  .auto_dir_en    (auto_dir_en),
  .tx_fifo_empty  (tx_fifo_empty),
  .tx_shift_empty (tx_shift_empty),
  .turn_delay     (turn_delay),
  .dir_on         (dir_on),
  .in_send        (in_send),
  .matched        (matched)
);

// File: tb/mdrop_ctl_tb_top.sv
module mdrop_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] rx_word;
  logic       rx_valid;
  logic [7:0] node_addr;
  logic       filt_en, pass_addr;
  logic       rx_accept;
  logic [7:0] rx_data;
  logic       auto_dir_en, dir_sel;
  logic       tx_fifo_empty, tx_shift_empty, bit_tick;
  logic [7:0] turn_delay;
  logic       man_rts, man_dtr, hwfc_en, hwfc_rts;
  logic       rts_out, dtr_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mdrop_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
    .node_addr(node_addr), .filt_en(filt_en), .pass_addr(pass_addr),
    .rx_accept(rx_accept), .rx_data(rx_data), .auto_dir_en(auto_dir_en),
    .dir_sel(dir_sel), .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .bit_tick(bit_tick), .turn_delay(turn_delay), .man_rts(man_rts), .man_dtr(man_dtr),
    .hwfc_en(hwfc_en), .hwfc_rts(hwfc_rts), .rts_out(rts_out), .dtr_out(dtr_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one word; returns the strobe and byte seen in the following cycle
  task automatic send_word(input logic [8:0] w, output logic acc, output logic [7:0] d);
    @(posedge clk); #1 rx_word = w; rx_valid = 1'b1;
    @(posedge clk); #1 rx_valid = 1'b0;
    acc = rx_accept; d = rx_data;
    @(posedge clk); #1;
  endtask

  task automatic tick_pulse();
    @(posedge clk); #1 bit_tick = 1'b1;
    @(posedge clk); #1 bit_tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx_word = '0; rx_valid = 1'b0; node_addr = 8'h5A;
    filt_en = 1'b0; pass_addr = 1'b0; auto_dir_en = 1'b1; dir_sel = 1'b0;
    tx_fifo_empty = 1'b0; tx_shift_empty = 1'b1; bit_tick = 1'b0; turn_delay = 8'd3;
    man_rts = 1'b1; man_dtr = 1'b0; hwfc_en = 1'b0; hwfc_rts = 1'b0;
    wait_cyc(3);
    chk("R1 rts during reset", rts_out, 0);
    chk("R1 accept during reset", rx_accept, 0);
    tx_fifo_empty = 1'b1; auto_dir_en = 1'b0;
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_no_filter();
    logic a; logic [7:0] d;
    filt_en = 1'b0;
    send_word(9'h0_3C, a, d);
    chk("R2 data accepted", a, 1); chk("R2 data byte", d, 8'h3C);
    send_word(9'h1_77, a, d);
    chk("R2 address word accepted", a, 1); chk("R2 address byte", d, 8'h77);
    chk("R2 strobe one cycle", rx_accept, 0);
  endtask

  task automatic t_filter();
    logic a; logic [7:0] d;
    filt_en = 1'b1; pass_addr = 1'b0;
    send_word(9'h0_11, a, d); chk("R3 unselected data dropped", a, 0);
    send_word(9'h1_22, a, d); chk("R4 foreign address dropped", a, 0);
    send_word(9'h0_33, a, d); chk("R4 data after foreign address dropped", a, 0);
    send_word(9'h1_5A, a, d); chk("R5 matching address dropped with pass off", a, 0);
    send_word(9'h0_44, a, d); chk("R5 selected data accepted", a, 1);
    chk("R5 selected data byte", d, 8'h44);
    send_word(9'h0_45, a, d); chk("R5 second data accepted", a, 1);
    send_word(9'h1_A5, a, d); chk("R4 other address deselects", a, 0);
    send_word(9'h0_46, a, d); chk("R4 data after deselect dropped", a, 0);
    pass_addr = 1'b1;
    send_word(9'h1_5A, a, d); chk("R5 matching address passed", a, 1);
    chk("R5 passed address byte", d, 8'h5A);
    send_word(9'h0_47, a, d); chk("R5 data after pass accepted", a, 1);
    filt_en = 1'b0; wait_cyc(1); filt_en = 1'b1;
    send_word(9'h0_48, a, d); chk("R3 data after re-enable dropped", a, 0);
  endtask

  task automatic start_char();
    tx_fifo_empty = 1'b0;
    @(posedge clk); #1;
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0;
  endtask

  task automatic t_turnaround();
    auto_dir_en = 1'b1; dir_sel = 1'b0; turn_delay = 8'd3;
    @(posedge clk); #1 tx_fifo_empty = 1'b0;
    chk("R6 off before fifo edge", rts_out, 0);
    @(posedge clk); #1;
    chk("R6 on after fifo non-empty", rts_out, 1);
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0;
    for (int i = 0; i < 4; i++) tick_pulse();
    chk("R7 on while shifting", rts_out, 1);
    tx_shift_empty = 1'b1;
    wait_cyc(3);
    chk("R7 no count without tick", rts_out, 1);
    for (int i = 1; i <= 3; i++) begin
      tick_pulse();
      chk($sformatf("R7 after tick %0d", i), rts_out, (i < 3) ? 1 : 0);
    end
  endtask

  task automatic t_zero_delay();
    turn_delay = 8'd0;
    start_char();
    chk("R8 on while shifting", rts_out, 1);
    wait_cyc(2);
    tx_shift_empty = 1'b1;
    @(posedge clk); #1;
    chk("R8 released next cycle", rts_out, 0);
  endtask

  task automatic t_cancel();
    turn_delay = 8'd3;
    start_char();
    wait_cyc(2);
    tx_shift_empty = 1'b1;
    tick_pulse();
    tick_pulse();
    chk("R9 still counting", rts_out, 1);
    tx_fifo_empty = 1'b0;
    @(posedge clk); #1;
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0;
    tick_pulse();
    chk("R9 kept on after new char", rts_out, 1);
    tx_shift_empty = 1'b1;
    tick_pulse();
    tick_pulse();
    chk("R9 full delay restarted", rts_out, 1);
    tick_pulse();
    chk("R9 released after full delay", rts_out, 0);
  endtask

  task automatic t_pins();
    turn_delay = 8'd0;
    auto_dir_en = 1'b1; dir_sel = 1'b0;
    man_rts = 1'b1; hwfc_en = 1'b1; hwfc_rts = 1'b1; man_dtr = 1'b1;
    wait_cyc(1);
    chk("R10 rts idle overrides sources", rts_out, 0);
    chk("R10 dtr follows manual", dtr_out, 1);
    dir_sel = 1'b1; man_rts = 1'b0; hwfc_rts = 1'b1; man_dtr = 1'b1;
    start_char();
    chk("R10 dtr carries direction", dtr_out, 1);
    man_dtr = 1'b0; #1;
    chk("R10 dtr ignores manual", dtr_out, 1);
    chk("R10 rts follows flow control", rts_out, 1);
    tx_shift_empty = 1'b1;
    @(posedge clk); #1;
    man_dtr = 1'b1; #1;
    chk("R10 dtr idle ignores manual", dtr_out, 0);
    auto_dir_en = 1'b0; hwfc_en = 1'b1; hwfc_rts = 1'b0; man_rts = 1'b1; #1;
    chk("R11 rts from flow control", rts_out, 0);
    hwfc_en = 1'b0; #1;
    chk("R11 rts from manual", rts_out, 1);
    chk("R11 dtr from manual", dtr_out, 1);
  endtask

  initial begin
    t_reset();
    t_no_filter();
    t_filter();
    t_turnaround();
    t_zero_delay();
    t_cancel();
    t_pins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule